// File: doc/BRIEF.md
# Floating-Point Immediate Constructor

This block builds floating-point constants in a 64-bit double-precision register image from 16-bit immediates. It has two operations. The load operation treats the immediate as the upper half of a single-precision pattern, clears the lower half, and widens that pattern to double precision. The splice operation takes the register's current double-format value and recovers the single-precision bit pattern it holds. It overwrites the lower 16 bits of that pattern with the immediate and widens the result again. A load followed by a splice therefore yields any single-precision constant, with the splice adding 16 bits of mantissa precision.

The caller presents an operation select, the immediate and the current register value together with a valid strobe. One cycle later the block presents the new register value with its own valid flag. A two-state control machine tracks the output: `ST_IDLE` (no result this cycle) and `ST_EMIT` (result valid). The named transitions are IDLE→EMIT on a strobe, EMIT→EMIT on a back-to-back strobe, EMIT→IDLE when the strobe drops, and IDLE→IDLE while nothing arrives. The result register loads only on a strobe and holds between strobes.

Top module: `fpimm_ctor`

## Requirements
- R1: With `op_i` = 0 (load), the result is the double-precision widening of the single pattern {imm_i, 16'h0000}; immediate 0x3F80 gives 0x3FF0000000000000 (+1.0).
- R2: With `op_i` = 1 (splice), the result is the widening of the single pattern recovered from `src_i` with its bits [15:0] replaced by `imm_i`; splicing 0x8000 into +1.0 gives 0x3FF0100000000000 (+1.00390625).
- R3: Widening a normal single (exponent field 1..254) adds 896 to the exponent field and places the 23 mantissa bits at double mantissa bits [51:29]. Result bits [28:0] are always zero.
- R4: Widening a single subnormal (exponent field 0, mantissa non-zero) normalises it. With z leading zeros in the 23-bit mantissa, the double exponent field is 896 − z and the mantissa is shifted left by z+1. Nothing is flushed to zero.
- R5: Widening keeps the sign bit, maps a signed zero to a signed zero, and maps exponent field 0xFF to 0x7FF with the mantissa (infinity or NaN payload) left-aligned at bits [51:29].
- R6: Recovery from `src_i` applies four rules. A double exponent field of 897..1150 gives single exponent field − 896 and the top 23 mantissa bits. A field of 874..896 gives a single subnormal, {1, top 23 mantissa bits} shifted right by 897 − field and truncated. A field of 0..873 gives a signed zero. A field of 1151..2046 gives a signed infinity.
- R7: Recovery of a double with exponent field 0x7FF keeps the top 23 mantissa bits. If the mantissa is non-zero but those 23 bits are all zero, the single mantissa becomes 0x400000, a quiet NaN, before splicing.
- R8: A cycle with `valid_i` high produces `valid_o` high, with the matching `result_o`, on the following clock edge; back-to-back strobes give back-to-back results in order.
- R9: After reset `valid_o` is 0 and `result_o` is 0. In a cycle following one with `valid_i` low, `valid_o` is 0 and `result_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 1 | 0 = load, 1 = splice |
| imm_i | input | 16 | Immediate |
| src_i | input | 64 | Current register value, double format |
| valid_o | output | 1 | Result valid, one cycle after the strobe |
| result_o | output | 64 | New register value, double format |

## Verification
Several properties are checked on every cycle:
- the one-cycle handshake, and the idle and hold behaviour between strobes;
- the all-zero low 29 bits of any widened result;
- sign pass-through on loads, and the 0x7FF exponent for loads with an all-ones exponent;
- the +1.0 load constant.

Value correctness needs the bench's scenarios:
- splicing into recovered patterns;
- subnormal normalisation;
- clamping of out-of-range doubles to zero or infinity;
- NaN quieting during recovery.

These are shown against a loop-based reference widening over random patterns from every exponent class, plus directed sources.

// File: rtl/fpimm_pkg.sv
package fpimm_pkg;

    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int DP_EXP_W = 11;
    localparam int DP_MAN_W = 52;
    localparam int IMM_W    = 16;

    localparam int SP_W      = 1 + SP_EXP_W + SP_MAN_W;
    localparam int DP_W      = 1 + DP_EXP_W + DP_MAN_W;
    localparam int SP_BIAS   = (1 << (SP_EXP_W - 1)) - 1;
    localparam int DP_BIAS   = (1 << (DP_EXP_W - 1)) - 1;
    localparam int BIAS_DIFF = DP_BIAS - SP_BIAS;
    localparam int MAN_PAD   = DP_MAN_W - SP_MAN_W;
    localparam int LZ_W      = $clog2(SP_MAN_W + 1);

    typedef enum logic {
        OP_LOAD   = 1'b0,
        OP_SPLICE = 1'b1
    } fpimm_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } fpimm_state_e;

    typedef struct packed {
        logic                sign;
        logic [SP_EXP_W-1:0] exp;
        logic [SP_MAN_W-1:0] man;
    } sp_t;

    typedef struct packed {
        logic                sign;
        logic [DP_EXP_W-1:0] exp;
        logic [DP_MAN_W-1:0] man;
    } dp_t;

endpackage

// File: rtl/fpimm_narrow.sv
module fpimm_narrow
    import fpimm_pkg::*;
(
    input  dp_t dp_i,
    output sp_t sp_o
);

    localparam int EXP_TOP      = DP_BIAS + SP_BIAS;
    localparam int EXP_NORM_MIN = BIAS_DIFF + 1;
    localparam int EXP_SUB_MIN  = EXP_NORM_MIN - SP_MAN_W;
    localparam logic [SP_MAN_W-1:0] QUIET_MAN = SP_MAN_W'(1) << (SP_MAN_W - 1);

    logic [SP_MAN_W-1:0] top_man;
    logic [SP_MAN_W:0]   full_sig;
    logic [SP_MAN_W:0]   shifted_sig;
    logic [DP_EXP_W-1:0] sub_shift;
    logic                low_man_set;

    assign top_man     = dp_i.man[DP_MAN_W-1 -: SP_MAN_W];
    assign low_man_set = |dp_i.man[MAN_PAD-1:0];
    assign full_sig    = {1'b1, top_man};
    assign sub_shift   = DP_EXP_W'(EXP_NORM_MIN) - dp_i.exp;
    assign shifted_sig = full_sig >> sub_shift;

    always_comb begin
        sp_o.sign = dp_i.sign;
        sp_o.exp  = '0;
        sp_o.man  = '0;
        if (dp_i.exp == '1) begin
            sp_o.exp = '1;
            if (top_man == '0 && low_man_set) begin
                sp_o.man = QUIET_MAN;
            end else begin
                sp_o.man = top_man;
            end
        end else if (dp_i.exp > DP_EXP_W'(EXP_TOP)) begin
            sp_o.exp = '1;
        end else if (dp_i.exp >= DP_EXP_W'(EXP_NORM_MIN)) begin
            sp_o.exp = SP_EXP_W'(dp_i.exp - DP_EXP_W'(BIAS_DIFF));
            sp_o.man = top_man;
        end else if (dp_i.exp >= DP_EXP_W'(EXP_SUB_MIN)) begin
            sp_o.man = shifted_sig[SP_MAN_W-1:0];
        end
    end

endmodule

// File: rtl/fpimm_widen.sv
module fpimm_widen
    import fpimm_pkg::*;
(
    input  sp_t sp_i,
    output dp_t dp_o
);

    logic [LZ_W-1:0]     lead_zeros;
    logic [LZ_W-1:0]     norm_shift;
    logic [SP_MAN_W-1:0] norm_man;

    always_comb begin
        lead_zeros = '0;
        for (int i = 0; i < SP_MAN_W; i++) begin
            if (sp_i.man[i]) begin
                lead_zeros = LZ_W'(SP_MAN_W - 1 - i);
            end
        end
    end

    assign norm_shift = lead_zeros + LZ_W'(1);
    assign norm_man   = sp_i.man << norm_shift;

    always_comb begin
        dp_o.sign = sp_i.sign;
        dp_o.exp  = '0;
        dp_o.man  = '0;
        if (sp_i.exp == '1) begin
            dp_o.exp = '1;
            dp_o.man = {sp_i.man, MAN_PAD'(0)};
        end else if (sp_i.exp == '0) begin
            if (sp_i.man != '0) begin
                dp_o.exp = DP_EXP_W'(BIAS_DIFF) - DP_EXP_W'(lead_zeros);
                dp_o.man = {norm_man, MAN_PAD'(0)};
            end
        end else begin
            dp_o.exp = DP_EXP_W'(sp_i.exp) + DP_EXP_W'(BIAS_DIFF);
            dp_o.man = {sp_i.man, MAN_PAD'(0)};
        end
    end

endmodule

// File: rtl/fpimm_ctor.sv
module fpimm_ctor
    import fpimm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic            op_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [DP_W-1:0] src_i,
    output logic            valid_o,
    output logic [DP_W-1:0] result_o
);

    fpimm_state_e   state_q;
    fpimm_state_e   state_d;
    dp_t            src_dp;
    sp_t            rec_sp;
    sp_t            built_sp;
    dp_t            built_dp;
    logic [SP_W-1:0] rec_bits;
    logic [SP_W-1:0] built_bits;
    logic [DP_W-1:0] result_q;

    assign src_dp   = dp_t'(src_i);
    assign rec_bits = SP_W'(rec_sp);

    fpimm_narrow u_narrow (
        .dp_i (src_dp),
        .sp_o (rec_sp)
    );

    always_comb begin
        unique case (fpimm_op_e'(op_i))
            OP_LOAD:   built_bits = {imm_i, IMM_W'(0)};
            OP_SPLICE: built_bits = {rec_bits[SP_W-1:IMM_W], imm_i};
            default:   built_bits = '0;
        endcase
    end

    assign built_sp = sp_t'(built_bits);

    fpimm_widen u_widen (
        .sp_i (built_sp),
        .dp_o (built_dp)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = valid_i ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = valid_i ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        valid_o  = (state_q == ST_EMIT);
        result_o = result_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (valid_i) begin
            result_q <= DP_W'(built_dp);
        end
    end

endmodule

// File: rtl/fpimm_ctor_chk.sv
module fpimm_ctor_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        valid_i,
    input logic        op_i,
    input logic [15:0] imm_i,
    input logic [63:0] src_i,
    input logic        valid_o,
    input logic [63:0] result_o
);

    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(result_o));

    assert_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (result_o[28:0] == 29'h0));

    assert_load_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !op_i) |=> (result_o[63] == $past(imm_i[15])));

    assert_load_special_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !op_i && imm_i[14:7] == 8'hFF) |=> (result_o[62:52] == 11'h7FF));

    assert_load_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !op_i && imm_i == 16'h3F80) |=> (result_o == 64'h3FF0_0000_0000_0000));

endmodule

bind fpimm_ctor fpimm_ctor_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_i),
    .op_i     (op_i),
    .imm_i    (imm_i),
    .src_i    (src_i),
    .valid_o  (valid_o),
    .result_o (result_o)
);

// File: tb/fpimm_ctor_test.sv
`timescale 1ns/1ps
module fpimm_ctor_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        op_i = 1'b0;
    logic [15:0] imm_i = '0;
    logic [63:0] src_i = '0;
    logic        valid_o;
    logic [63:0] result_o;

    int total = 0;
    int bad = 0;
    bit armed = 1'b0;
    bit done = 1'b0;
    logic [63:0] last_res = '0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    fpimm_ctor uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (valid_i),
        .op_i     (op_i),
        .imm_i    (imm_i),
        .src_i    (src_i),
        .valid_o  (valid_o),
        .result_o (result_o)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // reference widening, normalising by a stepwise loop
    function automatic logic [63:0] m_widen(input logic [31:0] s);
        logic [7:0]  e8;
        logic [22:0] f;
        logic [23:0] m;
        int          e;
        e8 = s[30:23];
        f  = s[22:0];
        if (e8 == 8'hFF) return {s[31], 11'h7FF, f, 29'b0};
        if (e8 == 8'h00 && f == 23'h0) return {s[31], 63'b0};
        if (e8 == 8'h00) begin
            m = {1'b0, f};
            e = -126;
            while (!m[23]) begin
                m = m << 1;
                e--;
            end
            return {s[31], 11'(e + 1023), m[22:0], 29'b0};
        end
        return {s[31], 11'(int'(e8) + 896), f, 29'b0};
    endfunction

    function automatic logic [31:0] rand_sp(input int cls);
        logic        sg;
        logic [7:0]  e8;
        logic [22:0] f;
        sg = 1'($urandom);
        f  = 23'($urandom);
        case (cls)
            0: begin e8 = 8'h00; f = 23'h0; end
            1: begin e8 = 8'h00; if (f == 23'h0) f = 23'h1; end
            2: e8 = 8'(1 + ($urandom % 254));
            3: begin e8 = 8'hFF; f = 23'h0; end
            default: begin e8 = 8'hFF; if (f == 23'h0) f = 23'h2; end
        endcase
        return {sg, e8, f};
    endfunction

    task automatic drive(input logic op, input logic [15:0] imm, input logic [63:0] src,
                         input logic [63:0] expv, input string tag);
        @(negedge clk);
        valid_i = 1'b1;
        op_i    = op;
        imm_i   = imm;
        src_i   = src;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid_i = 1'b0;
            imm_i   = 16'($urandom);
            src_i   = {32'($urandom), 32'($urandom)};
        end
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (armed) begin
                if (valid_o) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8 unexpected result", result_o, 64'h0);
                    end else begin
                        logic [63:0] ev;
                        string       tg;
                        ev = exp_q.pop_front();
                        tg = tag_q.pop_front();
                        check(result_o === ev, tg, result_o, ev);
                    end
                    last_res = result_o;
                end else begin
                    check(result_o === last_res, "R9 hold while idle", result_o, last_res);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] sp;
        logic [31:0] sp2;
        logic [15:0] im;
        repeat (3) @(negedge clk);
        #1;
        check(valid_o === 1'b0, "R9 reset valid", 64'(valid_o), 64'h0);
        check(result_o === 64'h0, "R9 reset result", result_o, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        armed = 1'b1;

        // R1 / R2 stated constants
        drive(1'b0, 16'h3F80, 64'h0, 64'h3FF0_0000_0000_0000, "R1 load one");
        drive(1'b1, 16'h8000, 64'h3FF0_0000_0000_0000, 64'h3FF0_1000_0000_0000, "R2 splice one");
        idle(2);

        // R6 recovery corner sources
        drive(1'b1, 16'h0007, 64'h3808_0000_0000_0001, m_widen(32'h0060_0007), "R6 sub recovery");
        drive(1'b1, 16'h5555, 64'h3690_0000_0000_0000, m_widen(32'h0000_5555), "R6 below range zero");
        drive(1'b1, 16'h1234, 64'h7E00_0000_0000_0000, m_widen(32'h7F80_1234), "R6 above range inf");
        drive(1'b1, 16'h0000, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000, "R6 tiny negative zero");
        // R7 quieting
        drive(1'b1, 16'h0000, 64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0000, "R7 nan quiet");
        drive(1'b1, 16'hBEEF, 64'hFFF0_0000_0000_1000, m_widen(32'hFFC0_BEEF), "R7 nan quiet neg");
        idle(1);

        // R5 zeros and specials on load
        drive(1'b0, 16'h8000, 64'h0, 64'h8000_0000_0000_0000, "R5 negative zero");
        drive(1'b0, 16'h0000, 64'h0, 64'h0, "R5 positive zero");
        drive(1'b0, 16'hFF80, 64'h0, 64'hFFF0_0000_0000_0000, "R5 negative inf");
        drive(1'b0, 16'h7FC1, 64'h0, 64'h7FF8_2000_0000_0000, "R5 nan payload");
        // R4 subnormal loads and splices
        drive(1'b0, 16'h0040, 64'h0, 64'h3800_0000_0000_0000, "R4 largest-bit subnormal");
        drive(1'b1, 16'h0001, 64'h0, 64'h36A0_0000_0000_0000, "R4 smallest subnormal");
        idle(3);

        // random patterns across all classes
        for (int k = 0; k < 400; k++) begin
            sp = rand_sp(k % 5);
            im = 16'($urandom);
            if (($urandom % 2) == 0) begin
                drive(1'b0, sp[31:16], 64'($urandom), m_widen({sp[31:16], 16'h0}), "R1 R3 random load");
            end else begin
                sp2 = {sp[31:16], im};
                drive(1'b1, im, m_widen(sp), m_widen(sp2), "R2 R4 R6 random splice");
            end
            if ((k % 7) == 3) idle(1 + (k % 3));
        end
        idle(4);
        check(exp_q.size() == 0, "R8 all results returned", 64'(exp_q.size()), 64'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule